// File: doc/BRIEF.md
# Nibble Expression Stack

This block holds the data stack of a small 4-bit processor core. The top element lives in a dedicated register that feeds the datapath directly. Every deeper element is kept in an external 256-nibble single-port RAM. An 8-bit pointer addresses that RAM and always names the location of the second element, the one just below the top.

A push moves the pointer up by one and, in the same clock, writes the old top value to the newly addressed RAM word. The new top value comes from one of four nibble sources picked by a select input. A pop copies the word under the pointer into the top register and moves the pointer down by one, again in a single clock. A replace command overwrites the top register from the selected source and leaves the stack depth alone. The pointer resets to zero, but software is expected to set it to the stack base through the pointer-load command before using the stack. Pointer arithmetic wraps modulo 256 and nothing detects overflow or underflow.

Top module: `nibble_stack`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the top value and the pointer read zero and the RAM write enable is low.
- R2: Pointer-load copies `sp_load_val` into the pointer at the next edge. It leaves the top value unchanged and does not write RAM.
- R3: Push drives `mem_we` high, `mem_addr` to pointer+1 and `mem_wdata` to the current top value in that cycle. At the edge the pointer becomes pointer+1 and the top value becomes the selected source.
- R4: Pop loads the top value from `mem_rdata` at the address held in the pointer. At the edge the pointer becomes pointer-1. RAM is not written.
- R5: The source select code works the same for push and replace: 0 picks `alu_nib`, 1 picks `rom_nib`, 2 picks `fetch_nib`, 3 picks `io_nib`.
- R6: Replace (`put_tos`) loads the top value from the selected source. It leaves the pointer unchanged and does not write RAM.
- R7: When several commands are raised together, the priority is pointer-load, then push, then pop, then replace. Only the winning command takes effect.
- R8: With no command raised, the top value and the pointer hold, whatever the source inputs do.
- R9: The pointer wraps modulo 256. A push at 0xFF writes address 0x00, and a pop at 0x00 leaves 0xFF.
- R10: Whenever no push is in progress, `mem_addr` equals the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_sp | input | 1 | Load the pointer from `sp_load_val` |
| sp_load_val | input | 8 | New pointer value |
| push | input | 1 | Push command |
| pop | input | 1 | Pop command |
| put_tos | input | 1 | Replace the top value without moving the pointer |
| src_sel | input | 2 | Source select for push and replace |
| alu_nib | input | 4 | Source 0: arithmetic result |
| rom_nib | input | 4 | Source 1: program memory nibble |
| fetch_nib | input | 4 | Source 2: RAM fetch nibble |
| io_nib | input | 4 | Source 3: I/O bus nibble |
| mem_rdata | input | 4 | Asynchronous read data from the stack RAM |
| tos | output | 4 | Top-of-stack value |
| sp | output | 8 | Stack pointer (address of the second element) |
| mem_addr | output | 8 | Stack RAM address |
| mem_we | output | 1 | Stack RAM write enable |
| mem_wdata | output | 4 | Stack RAM write data |

## Verification
Each of three stack bases (0x00, 0x7F, 0xFE) gets sixteen pushes that cycle through all four sources, followed by sixteen pops. This shows that RAM holds the right values in the right order, and that the bases at the top and bottom of the address space wrap correctly. A sweep of replace over every source code separates the four mux legs from one another. Combined command patterns confirm that only the winning command takes effect. Idle cycles with the source inputs toggling show that nothing drifts while no command is raised.

// File: rtl/nstk_pkg.sv
`timescale 1ns/1ps
package nstk_pkg;
    localparam int NIB_W = 4;
    localparam int PTR_W = 8;
    localparam int N_SRC = 4;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_LOAD,
        OP_PUSH,
        OP_POP,
        OP_PUT
    } op_e;
endpackage

// File: rtl/nstk_decode.sv
`timescale 1ns/1ps
module nstk_decode
    import nstk_pkg::*;
(
    input  logic load_i,
    input  logic push_i,
    input  logic pop_i,
    input  logic put_i,
    output op_e  op_o
);
    // fixed priority: pointer load, push, pop, replace
    always_comb begin
        if (load_i)      op_o = OP_LOAD;
        else if (push_i) op_o = OP_PUSH;
        else if (pop_i)  op_o = OP_POP;
        else if (put_i)  op_o = OP_PUT;
        else             op_o = OP_IDLE;
    end
endmodule

// File: rtl/nstk_ptr.sv
`timescale 1ns/1ps
module nstk_ptr
    import nstk_pkg::*;
#(
    parameter int AW = PTR_W
) (
    input  op_e           op_i,
    input  logic [AW-1:0] sp_q_i,
    input  logic [AW-1:0] sp_load_i,
    output logic [AW-1:0] sp_d_o,
    output logic [AW-1:0] addr_o,
    output logic          we_o
);
    localparam logic [AW-1:0] STEP = AW'(1);

    logic [AW-1:0] sp_up;
    logic [AW-1:0] sp_dn;

    assign sp_up = sp_q_i + STEP;
    assign sp_dn = sp_q_i - STEP;

    always_comb begin
        sp_d_o = sp_q_i;
        addr_o = sp_q_i;
        we_o   = 1'b0;
        unique case (op_i)
            OP_LOAD: sp_d_o = sp_load_i;
            OP_PUSH: begin
                // pre-increment: write goes to the new address
                sp_d_o = sp_up;
                addr_o = sp_up;
                we_o   = 1'b1;
            end
            OP_POP:  sp_d_o = sp_dn;  // read at old address, then step down
            default: ;
        endcase
    end
endmodule

// File: rtl/nstk_tos.sv
`timescale 1ns/1ps
module nstk_tos
    import nstk_pkg::*;
#(
    parameter  int DW   = NIB_W,
    parameter  int NSRC = N_SRC,
    localparam int SW   = $clog2(NSRC)
) (
    input  op_e                op_i,
    input  logic [SW-1:0]      sel_i,
    input  logic [NSRC*DW-1:0] src_i,
    input  logic [DW-1:0]      rdata_i,
    input  logic [DW-1:0]      tos_q_i,
    output logic [DW-1:0]      tos_d_o,
    output logic [DW-1:0]      wdata_o
);
    logic [DW-1:0] cand [NSRC];
    logic [DW-1:0] picked;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign cand[g] = src_i[g*DW +: DW];
    end

    assign picked  = cand[sel_i];
    assign wdata_o = tos_q_i;

    always_comb begin
        unique case (op_i)
            OP_PUSH, OP_PUT: tos_d_o = picked;
            OP_POP:          tos_d_o = rdata_i;
            default:         tos_d_o = tos_q_i;
        endcase
    end
endmodule

// File: rtl/nibble_stack.sv
`timescale 1ns/1ps
module nibble_stack
    import nstk_pkg::*;
#(
    parameter  int DW   = NIB_W,
    parameter  int AW   = PTR_W,
    localparam int NSRC = N_SRC,
    localparam int SW   = $clog2(NSRC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_sp,
    input  logic [AW-1:0] sp_load_val,
    input  logic          push,
    input  logic          pop,
    input  logic          put_tos,
    input  logic [SW-1:0] src_sel,
    input  logic [DW-1:0] alu_nib,
    input  logic [DW-1:0] rom_nib,
    input  logic [DW-1:0] fetch_nib,
    input  logic [DW-1:0] io_nib,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] tos,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata
);
    typedef struct packed {
        logic [AW-1:0] sp;
        logic [DW-1:0] tos;
    } state_t;

    state_t state_d, state_q;
    op_e    op;
    logic [AW-1:0] sp_nx;
    logic [DW-1:0] tos_nx;
    logic [NSRC*DW-1:0] src_bus;

    assign src_bus = {io_nib, fetch_nib, rom_nib, alu_nib};

    nstk_decode i_decode (
        .load_i (load_sp),
        .push_i (push),
        .pop_i  (pop),
        .put_i  (put_tos),
        .op_o   (op)
    );

    nstk_ptr #(.AW(AW)) i_ptr (
        .op_i      (op),
        .sp_q_i    (state_q.sp),
        .sp_load_i (sp_load_val),
        .sp_d_o    (sp_nx),
        .addr_o    (mem_addr),
        .we_o      (mem_we)
    );

    nstk_tos #(.DW(DW), .NSRC(NSRC)) i_tos (
        .op_i    (op),
        .sel_i   (src_sel),
        .src_i   (src_bus),
        .rdata_i (mem_rdata),
        .tos_q_i (state_q.tos),
        .tos_d_o (tos_nx),
        .wdata_o (mem_wdata)
    );

    always_comb begin
        state_d     = state_q;
        state_d.sp  = sp_nx;
        state_d.tos = tos_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign tos = state_q.tos;
    assign sp  = state_q.sp;
endmodule

// File: rtl/nstk_checker.sv
`timescale 1ns/1ps
module nstk_checker #(
    parameter int DW = 4,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load_sp,
    input logic [AW-1:0] sp_load_val,
    input logic          push,
    input logic          pop,
    input logic          put_tos,
    input logic [DW-1:0] mem_rdata,
    input logic [DW-1:0] tos,
    input logic [AW-1:0] sp,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic [DW-1:0] mem_wdata
);
    localparam logic [AW-1:0] ONE = AW'(1);

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |-> (tos == '0 && sp == '0 && !mem_we));

    a_r2_load_sp: assert property (@(posedge clk) disable iff (!rst_n)
        load_sp |=> (sp == $past(sp_load_val) && tos == $past(tos)));

    a_r2_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        load_sp |-> !mem_we);

    a_r3_push_port: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !load_sp) |-> (mem_we && mem_wdata == tos && mem_addr == sp + ONE));

    a_r3_push_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !load_sp) |=> (sp == $past(sp) + ONE));

    a_r4_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !load_sp) |=> (tos == $past(mem_rdata) && sp == $past(sp) - ONE));

    a_r6_put_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (put_tos && !pop && !push && !load_sp) |=> (sp == $past(sp)));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_sp && !push && !pop && !put_tos) |=> ($stable(sp) && $stable(tos)));

    a_r10_addr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |-> (mem_addr == sp));
endmodule

bind nibble_stack nstk_checker #(.DW(DW), .AW(AW)) i_nstk_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_sp     (load_sp),
    .sp_load_val (sp_load_val),
    .push        (push),
    .pop         (pop),
    .put_tos     (put_tos),
    .mem_rdata   (mem_rdata),
    .tos         (tos),
    .sp          (sp),
    .mem_addr    (mem_addr),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata)
);

// File: tb/test_nibble_stack.sv
`timescale 1ns/1ps
module test_nibble_stack;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_sp = 1'b0, push = 1'b0, pop = 1'b0, put_tos = 1'b0;
    logic [7:0] sp_load_val = '0;
    logic [1:0] src_sel = '0;
    logic [3:0] alu_nib = '0, rom_nib = '0, fetch_nib = '0, io_nib = '0;
    logic [3:0] mem_rdata;
    logic [3:0] tos, mem_wdata;
    logic [7:0] sp, mem_addr;
    logic       mem_we;

    logic [3:0] ram [256];
    logic [3:0] exp_mem [256];
    logic [3:0] exp_tos = '0;
    logic [7:0] exp_sp = '0;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nibble_stack i_nibble_stack (
        .clk(clk), .rst_n(rst_n), .load_sp(load_sp), .sp_load_val(sp_load_val),
        .push(push), .pop(pop), .put_tos(put_tos), .src_sel(src_sel),
        .alu_nib(alu_nib), .rom_nib(rom_nib), .fetch_nib(fetch_nib), .io_nib(io_nib),
        .mem_rdata(mem_rdata), .tos(tos), .sp(sp), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    assign mem_rdata = ram[mem_addr];
    always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] pick(input logic [1:0] s, input int seed);
        case (s)
            2'd0: return 4'(seed);
            2'd1: return 4'(seed * 3 + 1);
            2'd2: return 4'(seed ^ 5);
            default: return 4'(seed + 9);
        endcase
    endfunction

    // one command cycle; the expected outcome is derived from the requirements
    task automatic step(input logic ld, input logic ps, input logic pp, input logic pt,
                        input logic [1:0] s, input logic [7:0] spv, input int seed,
                        input string req);
        logic [7:0] nsp;
        @(negedge clk);
        load_sp = ld; push = ps; pop = pp; put_tos = pt;
        src_sel = s; sp_load_val = spv;
        alu_nib = pick(2'd0, seed); rom_nib = pick(2'd1, seed);
        fetch_nib = pick(2'd2, seed); io_nib = pick(2'd3, seed);
        #1;
        if (ld) begin
            chk({req, " R2 no write"}, int'(mem_we), 0);
            exp_sp = spv;
        end else if (ps) begin
            nsp = exp_sp + 8'd1;
            chk({req, " R3 we"}, int'(mem_we), 1);
            chk({req, " R3/R9 addr"}, int'(mem_addr), int'(nsp));
            chk({req, " R3 wdata"}, int'(mem_wdata), int'(exp_tos));
            exp_mem[nsp] = exp_tos;
            exp_sp = nsp;
            exp_tos = pick(s, seed);
        end else if (pp) begin
            chk({req, " R4 no write"}, int'(mem_we), 0);
            chk({req, " R10 addr"}, int'(mem_addr), int'(exp_sp));
            exp_tos = exp_mem[exp_sp];
            exp_sp = exp_sp - 8'd1;
        end else if (pt) begin
            chk({req, " R6 no write"}, int'(mem_we), 0);
            exp_tos = pick(s, seed);
        end else begin
            chk({req, " R10 addr"}, int'(mem_addr), int'(exp_sp));
        end
        @(posedge clk); #1;
        chk({req, " tos"}, int'(tos), int'(exp_tos));
        chk({req, " sp"}, int'(sp), int'(exp_sp));
        load_sp = 0; push = 0; pop = 0; put_tos = 0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram[i] = 4'(i * 7 + 3);
            exp_mem[i] = 4'(i * 7 + 3);
        end
        #12;
        chk("R1 reset tos", int'(tos), 0);
        chk("R1 reset sp", int'(sp), 0);
        chk("R1 reset we", int'(mem_we), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 after reset tos", int'(tos), 0);
        chk("R1 after reset sp", int'(sp), 0);

        // R3 R4 R5 R9: fill and drain at three bases
        foreach (bases_q[b]) begin end
        for (int b = 0; b < 3; b++) begin
            logic [7:0] base;
            base = (b == 0) ? 8'h00 : (b == 1) ? 8'h7F : 8'hFE;
            step(1, 0, 0, 0, 2'd0, base, 0, "R2 load base");
            for (int i = 0; i < 16; i++)
                step(0, 1, 0, 0, 2'(i), 8'h00, i + 16 * b, "R3/R5 push");
            for (int i = 0; i < 16; i++)
                step(0, 0, 1, 0, 2'd0, 8'h00, 0, "R4/R9 pop");
        end

        // R9: explicit wrap points
        step(1, 0, 0, 0, 2'd0, 8'hFF, 0, "R2 load FF");
        step(0, 1, 0, 0, 2'd3, 8'h00, 6, "R9 push wrap");
        chk("R9 sp after push wrap", int'(sp), 0);
        step(0, 0, 1, 0, 2'd0, 8'h00, 0, "R9 pop at 00");
        chk("R9 sp after pop wrap", int'(sp), 8'hFF);

        // R5 R6: replace through every source
        for (int s = 0; s < 4; s++)
            for (int v = 0; v < 4; v++)
                step(0, 0, 0, 1, 2'(s), 8'h00, v * 5 + s, "R5/R6 put");

        // R7: priority among combined commands
        step(1, 1, 1, 1, 2'd1, 8'h40, 3, "R7 load wins");
        step(0, 1, 1, 1, 2'd2, 8'h00, 11, "R7 push wins");
        step(0, 0, 1, 1, 2'd3, 8'h00, 12, "R7 pop wins");
        step(1, 0, 1, 0, 2'd0, 8'h22, 13, "R7 load over pop");

        // R8: idle with moving sources
        for (int i = 0; i < 6; i++)
            step(0, 0, 0, 0, 2'(i), 8'(i * 40), i * 7, "R8 idle");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    int bases_q [1];

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule